// File: doc/BRIEF.md
# Display Cursor Register Bank

This block holds the settings for a hardware display cursor: control, screen position, hotspot, size, two colors used in monochrome mode, and a 40-bit surface base address. Software writes these through a simple register bus. Each write lands in a staged copy. A cursor fetch and overlay engine reads only the active copy, which the block drives on dedicated outputs. Width and height come out already decoded to their true dimensions.

Staged values move into the active copy as one group, so the engine never sees half of an update. With the update lock clear, the move happens on a vsync pulse. With the lock set, vsync is ignored and staged writes wait until software clears the lock. The staged set is then committed on that clearing write, with no vsync needed. The base address is split over two words. The high word is only held until the low word is written, and the complete address then joins the staged set in a single step.

Top module: `cursor_regbank`

## Requirements
- R1: After reset all active outputs are zero except `cur_width` and `cur_height`, which are 1. `upd_pending` is 0 and every register reads 0.
- R2: A write updates the staged value, and a read returns that staged value in the next cycle. Active outputs change only on a commit.
- R3: When the lock is clear, a cycle with `vsync` high copies every staged value into the active outputs together, and `upd_pending` then reads 0.
- R4: While the lock is set (word 0, bit 0 = 1), `vsync` changes no active output and leaves `upd_pending` as it was.
- R5: A write of bit 0 = 0 to word 0 while the lock is set commits the whole staged set in that cycle, without `vsync`.
- R6: Word 7 holds base bits 39:32 and reads back at once, but changes neither the staged address nor `upd_pending`. A write to word 8 stages the address {word 7, wdata[31:12], 12'h000}. Word 8 reads back with its low 12 bits zero.
- R7: Word 4 holds width-1 in bits 6:0 and height-1 in bits 14:8. `cur_width` and `cur_height` are the field value plus 1, so 127 gives 128.
- R8: Word 1 holds the following fields:
  - bit 0: enable
  - bits 2:1: mode (0 mono, 1 one-bit AND color, 2 pre-multiplied alpha, 3 straight alpha)
  - bit 3: 2x magnify
  - bit 4: inverse transparent clamp

  Word 2 holds X in bits 13:0 and Y in bits 29:16. Word 3 holds hotspot X in bits 6:0 and hotspot Y in bits 14:8. Words 5 and 6 hold the two colors as {R[23:16], G[15:8], B[7:0]}.
- R9: A write to words 1 to 6 or 8 sets `upd_pending`. If that write falls in the same cycle as a commit, the active copy takes the earlier staged value and `upd_pending` stays 1.
- R10: Word addresses 9 to 15 read 0, and writes to them change no output or staged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Staged value at bus_addr (combinational) |
| vsync | input | 1 | Frame boundary pulse |
| cur_en | output | 1 | Active enable |
| cur_mode | output | 2 | Active color mode |
| cur_mag2x | output | 1 | Active 2x magnify |
| cur_inv_clamp | output | 1 | Active inverse transparent clamp |
| cur_x | output | 14 | Active X position |
| cur_y | output | 14 | Active Y position |
| cur_hot_x | output | 7 | Active hotspot X |
| cur_hot_y | output | 7 | Active hotspot Y |
| cur_width | output | 8 | Active width (1..128) |
| cur_height | output | 8 | Active height (1..128) |
| cur_color0 | output | 24 | Active first mono color |
| cur_color1 | output | 24 | Active second mono color |
| cur_base | output | 40 | Active surface base byte address |
| upd_pending | output | 1 | Staged update not yet committed |

## Verification
The bench aims vsync at a locked bank. A design that leaked writes past the lock would move `cur_x` before the unlock. It then clears the lock without any vsync. A design that waited for a frame would leave the old values active.

For the address, the high word is written alone first. A design that committed the high word early would show a mixed address, or raise `upd_pending` too soon. The low word is then written with its low 12 bits set, to catch a missing alignment mask.

Other targets:
- A staged write in the same cycle as vsync, which exposes a design that drops the new write or copies it into the active set too early.
- A size of 127.
- Writes to unmapped addresses.

// File: rtl/cursor_regbank.sv
module cursor_regbank #(
  parameter int XY_W = 14,
  parameter int HOT_W = 7,
  parameter int SZ_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              vsync,
  output logic              cur_en,
  output logic [1:0]        cur_mode,
  output logic              cur_mag2x,
  output logic              cur_inv_clamp,
  output logic [XY_W-1:0]   cur_x,
  output logic [XY_W-1:0]   cur_y,
  output logic [HOT_W-1:0]  cur_hot_x,
  output logic [HOT_W-1:0]  cur_hot_y,
  output logic [SZ_W:0]     cur_width,
  output logic [SZ_W:0]     cur_height,
  output logic [23:0]       cur_color0,
  output logic [23:0]       cur_color1,
  output logic [39:0]       cur_base,
  output logic              upd_pending
);
  localparam logic [3:0] A_LOCK = 4'd0, A_CTRL = 4'd1, A_POS = 4'd2, A_HOT = 4'd3,
                         A_SIZE = 4'd4, A_COL0 = 4'd5, A_COL1 = 4'd6, A_HI = 4'd7, A_LO = 4'd8;

  logic             lock_q, pend_q;
  logic [4:0]       ctrl_s, ctrl_a;
  logic [XY_W-1:0]  x_s, y_s, x_a, y_a;
  logic [HOT_W-1:0] hx_s, hy_s, hx_a, hy_a;
  logic [SZ_W-1:0]  w_s, h_s, w_a, h_a;
  logic [23:0]      c0_s, c1_s, c0_a, c1_a;
  logic [7:0]       hi_hold;
  logic [39:0]      base_s, base_a;

  wire wr_lock = bus_we && bus_addr == A_LOCK;
  wire wr_ctrl = bus_we && bus_addr == A_CTRL;
  wire wr_pos  = bus_we && bus_addr == A_POS;
  wire wr_hot  = bus_we && bus_addr == A_HOT;
  wire wr_size = bus_we && bus_addr == A_SIZE;
  wire wr_c0   = bus_we && bus_addr == A_COL0;
  wire wr_c1   = bus_we && bus_addr == A_COL1;
  wire wr_hi   = bus_we && bus_addr == A_HI;
  wire wr_lo   = bus_we && bus_addr == A_LO;

  wire staged_wr = wr_ctrl | wr_pos | wr_hot | wr_size | wr_c0 | wr_c1 | wr_lo;
  wire unlock    = wr_lock && lock_q && !bus_wdata[0];
  wire commit    = unlock || (vsync && !lock_q && pend_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0; pend_q <= 1'b0;
      ctrl_s <= '0; x_s <= '0; y_s <= '0; hx_s <= '0; hy_s <= '0;
      w_s <= '0; h_s <= '0; c0_s <= '0; c1_s <= '0; hi_hold <= '0; base_s <= '0;
      ctrl_a <= '0; x_a <= '0; y_a <= '0; hx_a <= '0; hy_a <= '0;
      w_a <= '0; h_a <= '0; c0_a <= '0; c1_a <= '0; base_a <= '0;
    end else begin
      if (wr_lock) lock_q <= bus_wdata[0];
      if (wr_ctrl) ctrl_s <= bus_wdata[4:0];
      if (wr_pos) begin
        x_s <= bus_wdata[XY_W-1:0];
        y_s <= bus_wdata[16+XY_W-1:16];
      end
      if (wr_hot) begin
        hx_s <= bus_wdata[HOT_W-1:0];
        hy_s <= bus_wdata[8+HOT_W-1:8];
      end
      if (wr_size) begin
        w_s <= bus_wdata[SZ_W-1:0];
        h_s <= bus_wdata[8+SZ_W-1:8];
      end
      if (wr_c0) c0_s <= bus_wdata[23:0];
      if (wr_c1) c1_s <= bus_wdata[23:0];
      if (wr_hi) hi_hold <= bus_wdata[7:0];
      if (wr_lo) base_s <= {hi_hold, bus_wdata[31:12], 12'h000};
      if (commit) begin
        ctrl_a <= ctrl_s; x_a <= x_s; y_a <= y_s; hx_a <= hx_s; hy_a <= hy_s;
        w_a <= w_s; h_a <= h_s; c0_a <= c0_s; c1_a <= c1_s; base_a <= base_s;
      end
      if (staged_wr)   pend_q <= 1'b1;
      else if (commit) pend_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LOCK: bus_rdata[0] = lock_q;
      A_CTRL: bus_rdata[4:0] = ctrl_s;
      A_POS: begin
        bus_rdata[XY_W-1:0] = x_s;
        bus_rdata[16+XY_W-1:16] = y_s;
      end
      A_HOT: begin
        bus_rdata[HOT_W-1:0] = hx_s;
        bus_rdata[8+HOT_W-1:8] = hy_s;
      end
      A_SIZE: begin
        bus_rdata[SZ_W-1:0] = w_s;
        bus_rdata[8+SZ_W-1:8] = h_s;
      end
      A_COL0: bus_rdata[23:0] = c0_s;
      A_COL1: bus_rdata[23:0] = c1_s;
      A_HI:   bus_rdata[7:0] = hi_hold;
      A_LO:   bus_rdata = base_s[31:0];
      default: bus_rdata = '0;
    endcase
  end

  assign cur_en        = ctrl_a[0];
  assign cur_mode      = ctrl_a[2:1];
  assign cur_mag2x     = ctrl_a[3];
  assign cur_inv_clamp = ctrl_a[4];
  assign cur_x         = x_a;
  assign cur_y         = y_a;
  assign cur_hot_x     = hx_a;
  assign cur_hot_y     = hy_a;
  assign cur_width     = {1'b0, w_a} + 1'b1;
  assign cur_height    = {1'b0, h_a} + 1'b1;
  assign cur_color0    = c0_a;
  assign cur_color1    = c1_a;
  assign cur_base      = base_a;
  assign upd_pending   = pend_q;
endmodule

// File: rtl/cursor_regbank_chk.sv
module cursor_regbank_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_we,
  input logic [3:0]  bus_addr,
  input logic        bus_wdata0,
  input logic        vsync,
  input logic        lock_q,
  input logic [13:0] cur_x,
  input logic [1:0]  cur_mode,
  input logic [23:0] cur_color0,
  input logic [7:0]  cur_width,
  input logic [7:0]  cur_height,
  input logic [39:0] cur_base,
  input logic        upd_pending
);
  // R2
  no_commit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!vsync && !bus_we) |=> ($stable(cur_x) && $stable(cur_mode) && $stable(cur_color0)));
  // R3
  vsync_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!lock_q && vsync && !bus_we) |=> !upd_pending);
  // R4
  locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_q && vsync && !(bus_we && bus_addr == 4'd0)) |=> ($stable(cur_x) && $stable(cur_base) && $stable(cur_width)));
  // R5
  unlock_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_q && bus_we && bus_addr == 4'd0 && !bus_wdata0) |=> (!upd_pending && !lock_q));
  // R6
  hi_no_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 4'd7 && !upd_pending) |=> !upd_pending);
  // R6
  base_align_chk: assert property (@(posedge clk) disable iff (rst)
    cur_base[11:0] == 12'h000);
  // R7
  size_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_width != 8'd0 && cur_height != 8'd0));
endmodule

bind cursor_regbank cursor_regbank_chk u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata0(bus_wdata[0]),
  .vsync(vsync), .lock_q(lock_q), .cur_x(cur_x), .cur_mode(cur_mode),
  .cur_color0(cur_color0), .cur_width(cur_width), .cur_height(cur_height),
  .cur_base(cur_base), .upd_pending(upd_pending)
);

// File: tb/cursor_regbank_bench.sv
module cursor_regbank_bench;
  logic clk = 0, rst = 1, bus_we = 0, vsync = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic cur_en, cur_mag2x, cur_inv_clamp, upd_pending;
  logic [1:0] cur_mode;
  logic [13:0] cur_x, cur_y;
  logic [6:0] cur_hot_x, cur_hot_y;
  logic [7:0] cur_width, cur_height;
  logic [23:0] cur_color0, cur_color1;
  logic [39:0] cur_base;

  always #2 clk = ~clk;

  cursor_regbank u_cursor_regbank (.*);

  int checks = 0, errors = 0, cycles = 0;

  // reference model: index 0 ctrl,1 x,2 y,3 hx,4 hy,5 w,6 h,7 c0,8 c1
  longint sh[9], ac[9];
  longint sh_base, ac_base, hi_hold;
  bit m_lock, m_pend;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint model_read(int a);
    case (a)
      0: return longint'(m_lock);
      1: return sh[0];
      2: return sh[1] | (sh[2] << 16);
      3: return sh[3] | (sh[4] << 8);
      4: return sh[5] | (sh[6] << 8);
      5: return sh[7];
      6: return sh[8];
      7: return hi_hold;
      8: return sh_base & 64'hFFFF_FFFF;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (sh[i]) begin sh[i] = 0; ac[i] = 0; end
      sh_base = 0; ac_base = 0; hi_hold = 0; m_lock = 0; m_pend = 0;
    end else begin
      bit do_commit, staged;
      int a;
      a = int'(bus_addr);
      do_commit = (bus_we && a == 0 && m_lock && !bus_wdata[0]) || (vsync && !m_lock && m_pend);
      staged = bus_we && ((a >= 1 && a <= 6) || a == 8);
      if (do_commit) begin
        foreach (sh[i]) ac[i] = sh[i];
        ac_base = sh_base;
      end
      if (bus_we) begin
        case (a)
          0: m_lock = bus_wdata[0];
          1: sh[0] = bus_wdata & 32'h1F;
          2: begin sh[1] = bus_wdata & 32'h3FFF; sh[2] = (bus_wdata >> 16) & 32'h3FFF; end
          3: begin sh[3] = bus_wdata & 32'h7F; sh[4] = (bus_wdata >> 8) & 32'h7F; end
          4: begin sh[5] = bus_wdata & 32'h7F; sh[6] = (bus_wdata >> 8) & 32'h7F; end
          5: sh[7] = bus_wdata & 32'hFF_FFFF;
          6: sh[8] = bus_wdata & 32'hFF_FFFF;
          7: hi_hold = bus_wdata & 32'hFF;
          8: sh_base = (hi_hold << 32) | (bus_wdata & 32'hFFFF_F000);
          default: ;
        endcase
      end
      if (staged) m_pend = 1;
      else if (do_commit) m_pend = 0;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R8 enable", cur_en, ac[0] & 1);
      chk("R8 mode", cur_mode, (ac[0] >> 1) & 3);
      chk("R8 magnify", cur_mag2x, (ac[0] >> 3) & 1);
      chk("R8 clamp", cur_inv_clamp, (ac[0] >> 4) & 1);
      chk("R3 x", cur_x, ac[1]);
      chk("R3 y", cur_y, ac[2]);
      chk("R3 hot", {cur_hot_y, cur_hot_x}, (ac[4] << 7) | ac[3]);
      chk("R7 width", cur_width, ac[5] + 1);
      chk("R7 height", cur_height, ac[6] + 1);
      chk("R3 colors", {cur_color1, cur_color0}, (ac[8] << 24) | ac[7]);
      chk("R6 base", cur_base, ac_base);
      chk("R9 pending", upd_pending, m_pend);
      chk("R2 readback", bus_rdata, model_read(int'(bus_addr)));
    end
    if (cycles > 60000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<60000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(int a, logic [31:0] d, bit vs = 0);
    @(posedge clk); #1;
    bus_we = 1; bus_addr = a[3:0]; bus_wdata = d; vsync = vs;
    @(posedge clk); #1;
    bus_we = 0; vsync = 0;
  endtask

  task automatic pulse();
    @(posedge clk); #1; vsync = 1;
    @(posedge clk); #1; vsync = 0;
  endtask

  task automatic rd(int a, longint exp, string req);
    bus_addr = a[3:0]; #1;
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    #1;
    chk("R1 width", cur_width, 1); chk("R1 height", cur_height, 1);
    chk("R1 base", cur_base, 0); chk("R1 pending", upd_pending, 0);
    chk("R1 en", cur_en, 0);
    rd(1, 0, "R1 read");

    wr(1, 32'h0D);
    rd(1, 32'h0D, "R2 ctrl readback");
    chk("R2 en held", cur_en, 0); chk("R9 pending set", upd_pending, 1);
    pulse();
    chk("R3 en", cur_en, 1); chk("R8 mode=2", cur_mode, 2); chk("R8 mag", cur_mag2x, 1);
    chk("R3 pending clear", upd_pending, 0);

    wr(0, 1);
    wr(2, {2'b0, 14'd500, 2'b0, 14'd1000});
    wr(4, 32'h7F7F);
    pulse();
    chk("R4 x held", cur_x, 0); chk("R4 width held", cur_width, 1); chk("R4 pending", upd_pending, 1);
    wr(0, 0);
    chk("R5 x", cur_x, 1000); chk("R5 y", cur_y, 500);
    chk("R7 width 128", cur_width, 128); chk("R7 height 128", cur_height, 128);
    chk("R5 pending", upd_pending, 0);

    wr(7, 32'hAB);
    rd(7, 32'hAB, "R6 hi readback");
    chk("R6 hi no pending", upd_pending, 0);
    pulse();
    chk("R6 base unchanged", cur_base, 0);
    wr(8, 32'h1234_5FFF);
    rd(8, 32'h1234_5000, "R6 lo aligned");
    chk("R6 pending", upd_pending, 1);
    pulse();
    chk("R6 base", cur_base, 40'hAB_1234_5000);

    wr(1, 32'h01, 1);
    chk("R9 old en", cur_en, 1); chk("R9 old mode", cur_mode, 2); chk("R9 still pending", upd_pending, 1);
    pulse();
    chk("R9 new mode", cur_mode, 0); chk("R9 new mag", cur_mag2x, 0);

    wr(12, 32'hFFFF_FFFF);
    rd(12, 0, "R10 unmapped read");
    chk("R10 no pending", upd_pending, 0);
    rd(1, 32'h01, "R10 ctrl untouched");

    for (int i = 0; i < 4000; i++) begin
      int a;
      a = $urandom_range(0, 11);
      @(posedge clk); #1;
      bus_we = ($urandom_range(0, 2) != 0);
      bus_addr = a[3:0];
      bus_wdata = (a == 0) ? {31'b0, ($urandom_range(0, 3) == 0)} : $urandom;
      vsync = ($urandom_range(0, 5) == 0);
    end
    @(posedge clk); #1; bus_we = 0; vsync = 0;
    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule